// File: doc/BRIEF.md
# Packed Double-Precision to Signed 32-bit Integer Converter

This unit turns two IEEE-754 double-precision numbers, carried side by side in one 128-bit word, into two signed 32-bit two's-complement integers packed into one 64-bit word. The two lanes are converted independently, but they share one 2-bit rounding control. Gradual-underflow (subnormal) inputs are converted by the normal IEEE rules and are never flushed to zero.

An operation is offered by raising `opValid` for one cycle. The result, a valid pulse and two status flags appear one clock later. The invalid flag reports NaN, infinity or out-of-range lanes. The precision flag reports a conversion that was valid but not exact. When `invalidMask` is high, an invalid lane returns the indefinite integer 0x80000000. When it is low, an invalid operation raises an exception request instead and leaves the previous result on the output.

Top module: `dbl2int_pair`

## Requirements
- R1: Input bits [63:0] convert into `resOut[31:0]` and input bits [127:64] convert into `resOut[63:32]`. The two lanes are independent of each other.
- R2: `rndMode` selects the rounding of inexact values for both lanes: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 truncates toward zero.
- R3: A lane holding an integral value in range, including +0 and -0 (which both give 0), converts exactly and contributes no flag.
- R4: The range test applies to the rounded value. A rounded value from -2^31 to 2^31-1 is valid. Any other rounded value is invalid, and under a set mask the lane returns 0x80000000.
- R5: A lane holding a NaN (quiet or signalling) or an infinity of either sign is invalid, and under a set mask it returns 0x80000000.
- R6: The precision flag is raised only by a lane that is valid and inexact; an invalid lane never raises it. A nonzero subnormal input rounds to 0, +1 or -1 according to the mode and raises precision.
- R7: `doneValid`, `flagInvalid` and `flagPrecision` are registered one cycle after `opValid`. Each flag is the OR over both lanes. All three are 0 in cycles that follow no operation.
- R8: When an operation has an invalid lane and `invalidMask` is 0, `excReq` is 1 in the result cycle and `resOut` keeps its previous value. Otherwise `excReq` is 0 and `resOut` takes the new result.
- R9: During reset, `resOut`, `doneValid`, `flagInvalid`, `flagPrecision` and `excReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Starts one conversion this cycle |
| srcIn | input | 128 | Two packed double-precision values |
| rndMode | input | 2 | Rounding selection shared by both lanes |
| invalidMask | input | 1 | 1 selects the indefinite result, 0 selects an exception request |
| resOut | output | 64 | Two packed signed 32-bit results |
| doneValid | output | 1 | Result and flags refer to the operation offered last cycle |
| flagInvalid | output | 1 | Some lane was NaN, infinite or out of range |
| flagPrecision | output | 1 | Some valid lane was inexact |
| excReq | output | 1 | Unmasked invalid: exception requested, result held |

## Verification
The bench aims at the edges of the signed range after rounding:
- 2147483647.5 rounds to nearest to 2^31, which is invalid, but it is valid under truncation.
- -2147483648.4 and -2147483648.6 are both valid when rounded toward zero, but -2147483648.6 is invalid when rounded toward minus infinity.

A design that tests the range before rounding, or that treats -2^31 as overflow, gives a wrong result or a wrong invalid flag on exactly these values.

Ties at .5 in all four modes catch rounding that does not go to even or that ignores the sign. Signed zeros and the smallest subnormals catch a unit that flushes denormals or raises precision on exact zeros.

Further cases check the lanes and the exception path:
- One lane is made invalid while the other is exact or inexact. This exposes flags that are not combined per lane, and precision that is raised by an invalid lane.
- An unmasked NaN follows a known result. This exposes a destination that is overwritten when it should be held.

A stream of random operands with exponents around the integer range is compared on every clock with a behavioural model built on real arithmetic.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
  localparam int FP_W    = 64;
  localparam int INT_W   = 32;
  localparam int EXP_W   = 11;
  localparam int MAN_W   = 52;
  localparam int LANES   = 2;
  localparam int BIAS    = 1023;
  localparam int SH_BASE = BIAS + MAN_W;
  localparam int SH_W    = $clog2(FP_W);

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_DOWN      = 2'b01,
    RND_UP        = 2'b10,
    RND_ZERO      = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic loadRes;
    logic raiseExc;
    logic opDone;
  } ctrl_strobe_t;
endpackage

// File: rtl/dbl2int_lane.sv
module dbl2int_lane
  import dbl2int_pkg::*;
(
  input  logic [FP_W-1:0]  fpIn,
  input  rnd_mode_e        rndMode,
  output logic [INT_W-1:0] intOut,
  output logic             laneInvalid,
  output logic             laneInexact
);
  localparam logic [EXP_W:0]   SHIFT_BASE = (EXP_W+1)'(SH_BASE);
  localparam logic [EXP_W:0]   SHIFT_MAX  = (EXP_W+1)'(FP_W-1);
  localparam logic [FP_W-1:0]  NEG_LIM    = {{(FP_W-1){1'b0}}, 1'b1} << (INT_W-1);
  localparam logic [FP_W-1:0]  POS_LIM    = NEG_LIM - 1'b1;
  localparam logic [INT_W-1:0] INDEF      = {1'b1, {(INT_W-1){1'b0}}};

  logic             signBit;
  logic [EXP_W-1:0] expField;
  logic [EXP_W:0]   expEff;
  logic [EXP_W:0]   shDiff;
  logic [SH_W-1:0]  shAmt;
  logic [FP_W-1:0]  sig, intPart, lowMask, fracBits, mag;
  logic             special, tooBig, halfBit, stickyBit, anyFrac, roundUp, inRange;

  always_comb begin
    signBit  = fpIn[FP_W-1];
    expField = fpIn[FP_W-2 -: EXP_W];
    sig      = {{(FP_W-MAN_W-1){1'b0}}, (expField != '0), fpIn[MAN_W-1:0]};
    special  = &expField;
    expEff   = (expField == '0) ? (EXP_W+1)'(1) : {1'b0, expField};
    tooBig   = expEff > SHIFT_BASE;
    shDiff   = tooBig ? '0 : (SHIFT_BASE - expEff);
    shAmt    = (shDiff > SHIFT_MAX) ? SHIFT_MAX[SH_W-1:0] : shDiff[SH_W-1:0];
    intPart  = sig >> shAmt;
    lowMask  = ({{(FP_W-1){1'b0}}, 1'b1} << shAmt) - 1'b1;
    fracBits = sig & lowMask;
    anyFrac  = fracBits != '0;
    halfBit  = (shAmt == '0) ? 1'b0 : sig[shAmt - 1'b1];
    stickyBit = (fracBits & (lowMask >> 1)) != '0;
    unique case (rndMode)
      RND_NEAR_EVEN: roundUp = halfBit & (stickyBit | intPart[0]);
      RND_DOWN:      roundUp = signBit & anyFrac;
      RND_UP:        roundUp = ~signBit & anyFrac;
      default:       roundUp = 1'b0;
    endcase
    mag         = intPart + FP_W'(roundUp);
    inRange     = signBit ? (mag <= NEG_LIM) : (mag <= POS_LIM);
    laneInvalid = special | tooBig | ~inRange;
    laneInexact = anyFrac & ~laneInvalid;
    intOut      = laneInvalid ? INDEF
                : (signBit ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0]);
  end

  // R4
  always_comb begin
    indef_sign_chk: assert (laneInvalid || intOut != INDEF || signBit);
  end
endmodule

// File: rtl/dbl2int_dp.sv
module dbl2int_dp
  import dbl2int_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES*FP_W-1:0]  srcIn,
  input  rnd_mode_e              rndMode,
  input  ctrl_strobe_t           strobe,
  output logic                   anyInvalid,
  output logic                   anyInexact,
  output logic [LANES*INT_W-1:0] resOut
);
  logic [LANES-1:0]       invVec, inxVec;
  logic [LANES*INT_W-1:0] laneRes;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dbl2int_lane u_lane (
      .fpIn       (srcIn[g*FP_W +: FP_W]),
      .rndMode    (rndMode),
      .intOut     (laneRes[g*INT_W +: INT_W]),
      .laneInvalid(invVec[g]),
      .laneInexact(inxVec[g])
    );
  end

  assign anyInvalid = |invVec;
  assign anyInexact = |inxVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resOut <= '0;
    else if (strobe.loadRes) resOut <= laneRes;
  end
endmodule

// File: rtl/dbl2int_ctrl.sv
module dbl2int_ctrl
  import dbl2int_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic         invalidMask,
  input  logic         anyInvalid,
  input  logic         anyInexact,
  output ctrl_strobe_t strobe,
  output logic         doneValid,
  output logic         flagInvalid,
  output logic         flagPrecision,
  output logic         excReq
);
  always_comb begin
    strobe.opDone   = opValid;
    strobe.raiseExc = opValid & anyInvalid & ~invalidMask;
    strobe.loadRes  = opValid & ~strobe.raiseExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid     <= 1'b0;
      flagInvalid   <= 1'b0;
      flagPrecision <= 1'b0;
      excReq        <= 1'b0;
    end else begin
      doneValid     <= strobe.opDone;
      flagInvalid   <= opValid & anyInvalid;
      flagPrecision <= opValid & anyInexact;
      excReq        <= strobe.raiseExc;
    end
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(opValid));

  // R8
  exc_unmask_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (!$past(invalidMask) && flagInvalid));
endmodule

// File: rtl/dbl2int_pair.sv
module dbl2int_pair
  import dbl2int_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   opValid,
  input  logic [LANES*FP_W-1:0]  srcIn,
  input  logic [1:0]             rndMode,
  input  logic                   invalidMask,
  output logic [LANES*INT_W-1:0] resOut,
  output logic                   doneValid,
  output logic                   flagInvalid,
  output logic                   flagPrecision,
  output logic                   excReq
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  ctrl_strobe_t strobe;
  logic         anyInvalid, anyInexact;

  dbl2int_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .rndMode   (rnd_mode_e'(rndMode)),
    .strobe    (strobe),
    .anyInvalid(anyInvalid),
    .anyInexact(anyInexact),
    .resOut    (resOut)
  );

  dbl2int_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .invalidMask  (invalidMask),
    .anyInvalid   (anyInvalid),
    .anyInexact   (anyInexact),
    .strobe       (strobe),
    .doneValid    (doneValid),
    .flagInvalid  (flagInvalid),
    .flagPrecision(flagPrecision),
    .excReq       (excReq)
  );

  // R8
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $stable(resOut));

  // R4
  indef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && flagInvalid && !excReq) |->
      (resOut[INT_W-1:0] == INDEF || resOut[2*INT_W-1:INT_W] == INDEF));
endmodule

// File: tb/dbl2int_pair_tb.sv
module dbl2int_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [127:0] srcIn = '0;
  logic [1:0]   rndMode = 2'b00;
  logic         invalidMask = 1'b1;
  logic [63:0]  resOut;
  logic         doneValid, flagInvalid, flagPrecision, excReq;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  string curTag = "R9";

  logic [63:0] expRes = '0;
  bit expDone = 0, expInv = 0, expPrec = 0, expExc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl2int_pair u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .srcIn(srcIn),
    .rndMode(rndMode), .invalidMask(invalidMask), .resOut(resOut),
    .doneValid(doneValid), .flagInvalid(flagInvalid),
    .flagPrecision(flagPrecision), .excReq(excReq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic checkAll();
    chk(curTag, "resOut", resOut, expRes);
    chk("R7", "doneValid", 64'(doneValid), 64'(expDone));
    chk(curTag, "flagInvalid", 64'(flagInvalid), 64'(expInv));
    chk(curTag, "flagPrecision", 64'(flagPrecision), 64'(expPrec));
    chk(curTag == "R9" ? "R9" : "R8", "excReq", 64'(excReq), 64'(expExc));
  endtask

  task automatic refLane(input logic [63:0] b, input logic [1:0] m,
                         output logic [31:0] res, output bit inv, output bit inx);
    real r, f, q, d;
    integer iv;
    if (b[62:52] == 11'h7FF) begin
      res = 32'h8000_0000; inv = 1; inx = 0;
      return;
    end
    r = $bitstoreal(b);
    case (m)
      2'b00: begin
        f = $floor(r); d = r - f;
        if (d > 0.5) q = f + 1.0;
        else if (d < 0.5) q = f;
        else q = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      2'b01: q = $floor(r);
      2'b10: q = $ceil(r);
      default: q = (r < 0.0) ? $ceil(r) : $floor(r);
    endcase
    if (q < -2147483648.0 || q > 2147483647.0) begin
      res = 32'h8000_0000; inv = 1; inx = 0;
    end else begin
      iv = $rtoi(q);
      res = iv; inv = 0; inx = (q != r);
    end
  endtask

  task automatic stim(input bit v, input logic [63:0] hi, input logic [63:0] lo,
                      input logic [1:0] m, input bit mask, input string tag);
    logic [31:0] rHi, rLo;
    bit iHi, iLo, xHi, xLo;
    @(negedge clk);
    checkAll();
    opValid = v; srcIn = {hi, lo}; rndMode = m; invalidMask = mask;
    refLane(hi, m, rHi, iHi, xHi);
    refLane(lo, m, rLo, iLo, xLo);
    expDone = v;
    expInv  = v && (iHi || iLo);
    expPrec = v && (xHi || xLo);
    expExc  = v && (iHi || iLo) && !mask;
    if (v && !expExc) expRes = {rHi, rLo};
    curTag = tag;
  endtask

  function automatic logic [63:0] d2b(input real x);
    return $realtobits(x);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL R7 watchdog expired got running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    repeat (3) begin
      @(negedge clk);
      checkAll();  // R9 reset state
    end
    rstN = 1'b1;
    // R1 lane placement, R3 exact values and signed zeros
    stim(1, d2b(7.0), d2b(-3.0), 2'b00, 1, "R1");
    stim(1, d2b(0.0), 64'h8000_0000_0000_0000, 2'b01, 1, "R3");
    stim(1, d2b(-2147483648.0), d2b(2147483647.0), 2'b11, 1, "R3");
    // R2 ties and fractions in every mode
    for (int m = 0; m < 4; m++) begin
      stim(1, d2b(2.5), d2b(1.5), 2'(m), 1, "R2");
      stim(1, d2b(-2.5), d2b(-1.5), 2'(m), 1, "R2");
      stim(1, d2b(0.3), d2b(-0.7), 2'(m), 1, "R2");
    end
    // R6 subnormals in every mode
    for (int m = 0; m < 4; m++)
      stim(1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'(m), 1, "R6");
    // R4 range after rounding at both ends
    stim(1, d2b(2147483647.5), d2b(2147483647.4), 2'b00, 1, "R4");
    stim(1, d2b(2147483647.5), d2b(2147483647.9), 2'b11, 1, "R4");
    stim(1, d2b(-2147483648.4), d2b(-2147483648.6), 2'b11, 1, "R4");
    stim(1, d2b(-2147483648.6), d2b(-2147483648.4), 2'b01, 1, "R4");
    stim(1, d2b(-2147483649.0), d2b(2147483648.0), 2'b00, 1, "R4");
    stim(1, d2b(1.0e20), d2b(-1.0e300), 2'b10, 1, "R4");
    // R5 NaN and infinities, R6 invalid lane gives no precision
    stim(1, 64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'b00, 1, "R5");
    stim(1, 64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b11, 1, "R5");
    stim(1, 64'h7FF8_0000_0000_0000, d2b(12.0), 2'b00, 1, "R6");
    stim(1, d2b(3.25), 64'hFFF0_0000_0000_0000, 2'b00, 1, "R6");
    // R7 idle cycles clear flags
    stim(0, d2b(3.25), d2b(0.5), 2'b00, 1, "R7");
    stim(0, '0, '0, 2'b00, 1, "R7");
    // R8 unmasked invalid holds the destination
    stim(1, d2b(5.0), d2b(-9.0), 2'b00, 0, "R8");
    stim(1, 64'h7FF8_0000_0000_0000, d2b(1.5), 2'b00, 0, "R8");
    stim(1, d2b(4.0e9), d2b(2.0), 2'b11, 0, "R8");
    stim(0, '0, '0, 2'b00, 0, "R8");
    stim(1, d2b(6.6), d2b(-6.6), 2'b00, 0, "R8");
    // random operands near the int32 range
    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      ra[62:52] = 11'(1000 + ($urandom % 60));
      rb[62:52] = 11'(1000 + ($urandom % 60));
      stim(($urandom % 5) != 0, ra, rb, 2'($urandom), ($urandom % 4) != 0, "R2");
    end
    stim(0, '0, '0, 2'b00, 1, "R7");
    @(negedge clk);
    checkAll();
    finished = 1;
    summary();
    $finish;
  end
endmodule